// File: doc/BRIEF.md
# Conditional Skip Comparator

This unit decides whether a skip-style branch is taken. The processor it serves has no conditional jumps. It evaluates a condition on its two 8-bit operand caches, and when the condition is true the program counter steps over the next two instructions. The low three bits of the command byte select the condition. Command bit 7 selects how the operands are read: clear means two's-complement signed, set means unsigned.

A single-cycle evaluate strobe triggers the unit. On the following clock edge the unit produces four outputs:

- a one-cycle result-valid pulse;
- a skip request, which is high only when the condition held;
- the number of ticks the instruction consumes;
- the program-counter step, counted in 16-bit words.

The program counter itself lives outside this block.

Top module: `skip_cond_unit`

## Requirements
- R1: While reset is applied, and until the first evaluate after reset is released, `skip_o`, `done_o`, `ticks_o` and `pc_step_o` are all zero.
- R2: Condition code 0 (command bits [2:0] = 3'b000) never requests a skip. Condition code 7 (3'b111) always requests a skip, whatever the operands.
- R3: With command bit 7 = 0, the operands are compared as signed 8-bit values. The codes are: 1 means A > B, 3 means A >= B, 4 means A < B and 6 means A <= B. For example, A = 0x80 is less than B = 0x01.
- R4: With command bit 7 = 1, the same codes compare the operands as unsigned values. For example, A = 0x80 is greater than B = 0x01.
- R5: Code 2 (A == B) and code 5 (A != B) give the same result whether command bit 7 is 0 or 1.
- R6: `done_o` is high for exactly the one cycle after each cycle in which `eval_i` was sampled high. `skip_o` can only be high in such a cycle.
- R7: When `done_o` is high, `ticks_o` is 3 if the skip is taken and 2 if it is not. When `done_o` is low, `ticks_o` is 0.
- R8: When `done_o` is high, `pc_step_o` is 3 if the skip is taken and 1 if it is not. When `done_o` is low, `pc_step_o` is 0.
- R9: Command bits [6:3] have no effect on the result.
- R10: Changes to the operands or the command while `eval_i` is low do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the unit leaves reset synchronously |
| eval_i | input | 1 | Evaluate strobe; operands and command are sampled in this cycle |
| cmd_i | input | 8 | Command byte: [2:0] condition code, [7] unsigned mode |
| op_a_i | input | 8 | Operand cache 0 |
| op_b_i | input | 8 | Operand cache 1 |
| done_o | output | 1 | Result valid, one cycle after an evaluate |
| skip_o | output | 1 | Skip-two-instructions request |
| ticks_o | output | 2 | Ticks consumed by the instruction (2 or 3) |
| pc_step_o | output | 2 | Program-counter step in words (1 or 3) |

## Verification
The assertions assume the following about the inputs:

- `eval_i` is held low during reset and for the two cycles in which the internal reset is still being released.
- The operands and command are stable at the clock edge that samples the strobe.

The bench keeps within these assumptions. It drives every input on the falling clock edge, keeps the strobe low for several cycles after reset is released, and samples results on the falling edge after the capturing rising edge.

// File: rtl/skc_pkg.sv
package skc_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned TICK_W = 2;
  localparam int unsigned STEP_W = 2;

  localparam logic [TICK_W-1:0] TICKS_TAKEN = 2'd3;
  localparam logic [TICK_W-1:0] TICKS_PLAIN = 2'd2;
  localparam logic [STEP_W-1:0] STEP_TAKEN  = 2'd3;
  localparam logic [STEP_W-1:0] STEP_PLAIN  = 2'd1;

  typedef enum logic [CODE_W-1:0] {
    CND_NEVER = 3'd0,
    CND_GT    = 3'd1,
    CND_EQ    = 3'd2,
    CND_GE    = 3'd3,
    CND_LT    = 3'd4,
    CND_NE    = 3'd5,
    CND_LE    = 3'd6,
    CND_ALWAYS= 3'd7
  } cond_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

endpackage

// File: rtl/skc_rst_sync.sv
module skc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/skc_compare.sv
module skc_compare
  import skc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         unsigned_i,
  output rel_t         rel_o
);

  logic ult;
  logic slt;
  logic same;
  logic sign_differs;
  logic lt_sel;

  always_comb begin
    same         = (a_i == b_i);
    ult          = (a_i < b_i);
    sign_differs = a_i[W-1] ^ b_i[W-1];
    // With differing signs the negative operand is smaller;
    // otherwise the magnitude order decides.
    slt          = sign_differs ? a_i[W-1] : ult;
    lt_sel       = unsigned_i ? ult : slt;
    rel_o.eq     = same;
    rel_o.lt     = lt_sel;
    rel_o.gt     = !lt_sel && !same;
  end

endmodule

// File: rtl/skc_select.sv
module skc_select
  import skc_pkg::*;
(
  input  cond_e code_i,
  input  rel_t  rel_i,
  output logic  hit_o
);

  always_comb begin
    unique case (code_i)
      CND_NEVER:  hit_o = 1'b0;
      CND_GT:     hit_o = rel_i.gt;
      CND_EQ:     hit_o = rel_i.eq;
      CND_GE:     hit_o = rel_i.gt | rel_i.eq;
      CND_LT:     hit_o = rel_i.lt;
      CND_NE:     hit_o = !rel_i.eq;
      CND_LE:     hit_o = rel_i.lt | rel_i.eq;
      CND_ALWAYS: hit_o = 1'b1;
      default:    hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/skc_result_reg.sv
module skc_result_reg
  import skc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic              hit_i,
  output logic              done_o,
  output logic              skip_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic [STEP_W-1:0] step_o
);

  logic              done_d, skip_d;
  logic [TICK_W-1:0] ticks_d;
  logic [STEP_W-1:0] step_d;
  logic              upd_en;

  // Registers update on a strobe, and once more to return to idle.
  always_comb begin
    upd_en  = eval_i | done_o;
    done_d  = eval_i;
    skip_d  = eval_i & hit_i;
    ticks_d = '0;
    step_d  = '0;
    if (eval_i) begin
      ticks_d = hit_i ? TICKS_TAKEN : TICKS_PLAIN;
      step_d  = hit_i ? STEP_TAKEN  : STEP_PLAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      skip_o  <= 1'b0;
      ticks_o <= '0;
      step_o  <= '0;
    end else if (upd_en) begin
      done_o  <= done_d;
      skip_o  <= skip_d;
      ticks_o <= ticks_d;
      step_o  <= step_d;
    end
  end

endmodule

// File: rtl/skip_cond_unit.sv
module skip_cond_unit
  import skc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic             done_o,
  output logic             skip_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic [STEP_W-1:0] pc_step_o
);

  logic  rst_int_n;
  rel_t  rel;
  cond_e code;
  logic  hit;

  skc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign code = cond_e'(cmd_i[CODE_W-1:0]);

  skc_compare #(.W(DATA_W)) u_cmp (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .unsigned_i (cmd_i[MODE_BIT]),
    .rel_o      (rel)
  );

  skc_select u_sel (
    .code_i (code),
    .rel_i  (rel),
    .hit_o  (hit)
  );

  skc_result_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .eval_i  (eval_i),
    .hit_i   (hit),
    .done_o  (done_o),
    .skip_o  (skip_o),
    .ticks_o (ticks_o),
    .step_o  (pc_step_o)
  );

endmodule

// File: rtl/skip_cond_unit_chk.sv
module skip_cond_unit_chk
  import skc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             eval_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic             done_o,
  input logic             skip_o,
  input logic [TICK_W-1:0] ticks_o,
  input logic [STEP_W-1:0] pc_step_o
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!done_o && !skip_o && ticks_o == '0 && pc_step_o == '0));

  a_r2_never: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[2:0] == 3'd0) |=> !skip_o);

  a_r2_always: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[2:0] == 3'd7) |=> skip_o);

  a_r5_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[2:0] == 3'd2) |=> (skip_o == ($past(op_a_i) == $past(op_b_i))));

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> done_o);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> (!done_o && !skip_o));

  a_r7_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ticks_o == (skip_o ? 2'd3 : 2'd2)));

  a_r7_ticks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (ticks_o == '0));

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_step_o == (skip_o ? 2'd3 : 2'd1)));

endmodule

bind skip_cond_unit skip_cond_unit_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eval_i    (eval_i),
  .cmd_i     (cmd_i),
  .op_a_i    (op_a_i),
  .op_b_i    (op_b_i),
  .done_o    (done_o),
  .skip_o    (skip_o),
  .ticks_o   (ticks_o),
  .pc_step_o (pc_step_o)
);

// File: tb/test_skip_cond_unit.sv
`timescale 1ns/1ps
module test_skip_cond_unit;

  logic       clk;
  logic       rst_n;
  logic       eval_i;
  logic [7:0] cmd_i, op_a_i, op_b_i;
  logic       done_o, skip_o;
  logic [1:0] ticks_o, pc_step_o;

  int n_chk;
  int n_fail;
  bit finished;

  skip_cond_unit i_skip_cond_unit (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cmd_i(cmd_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .done_o(done_o), .skip_o(skip_o),
    .ticks_o(ticks_o), .pc_step_o(pc_step_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit want_skip(input logic [7:0] cmd, input logic [7:0] a,
                                   input logic [7:0] b);
    int sa, sb;
    if (cmd[7]) begin sa = int'(a); sb = int'(b); end
    else begin sa = int'($signed(a)); sb = int'($signed(b)); end
    case (cmd[2:0])
      3'd0: return 1'b0;
      3'd1: return sa > sb;
      3'd2: return sa == sb;
      3'd3: return sa >= sb;
      3'd4: return sa < sb;
      3'd5: return sa != sb;
      3'd6: return sa <= sb;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "done idle", int'(done_o), 0);
    check(req, "skip idle", int'(skip_o), 0);
    check(req, "ticks idle", int'(ticks_o), 0);
    check(req, "step idle", int'(pc_step_o), 0);
  endtask

  // One strobe; results are checked on the next falling edge.
  task automatic eval_once(input string req, input logic [7:0] cmd,
                           input logic [7:0] a, input logic [7:0] b,
                           input bit exp_skip);
    @(negedge clk);
    eval_i = 1'b1; cmd_i = cmd; op_a_i = a; op_b_i = b;
    @(negedge clk);
    eval_i = 1'b0;
    check(req, $sformatf("done cmd=%h", cmd), int'(done_o), 1);
    check(req, $sformatf("skip cmd=%h a=%h b=%h", cmd, a, b), int'(skip_o), int'(exp_skip));
    check("R7", "ticks", int'(ticks_o), exp_skip ? 3 : 2);
    check("R8", "pc step", int'(pc_step_o), exp_skip ? 3 : 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; eval_i = 1'b0; cmd_i = 8'h27; op_a_i = 8'h00; op_b_i = 8'h00;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_constant;
    eval_once("R2", 8'h20, 8'h05, 8'h05, 1'b0);
    eval_once("R2", 8'hA0, 8'hFF, 8'h00, 1'b0);
    eval_once("R2", 8'h27, 8'h00, 8'h7F, 1'b1);
    eval_once("R2", 8'hA7, 8'h12, 8'h12, 1'b1);
  endtask

  task automatic t_ordered(input bit unsgn);
    logic [7:0] pa [6] = '{8'h80, 8'h01, 8'h7F, 8'hFF, 8'h33, 8'h00};
    logic [7:0] pb [6] = '{8'h01, 8'h80, 8'hFF, 8'h7F, 8'h33, 8'hFF};
    logic [2:0] codes [4] = '{3'd1, 3'd3, 3'd4, 3'd6};
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [7:0] cmd;
        cmd = {unsgn, 4'b0100, codes[c]};
        eval_once(unsgn ? "R4" : "R3", cmd, pa[i], pb[i],
                  want_skip(cmd, pa[i], pb[i]));
      end
    end
    // Explicit corner: 0x80 vs 0x01
    eval_once(unsgn ? "R4" : "R3", {unsgn, 7'h21}, 8'h80, 8'h01, unsgn);
  endtask

  task automatic t_eq_ne;
    eval_once("R5", 8'h22, 8'h9C, 8'h9C, 1'b1);
    eval_once("R5", 8'hA2, 8'h9C, 8'h9C, 1'b1);
    eval_once("R5", 8'h22, 8'h9C, 8'h1C, 1'b0);
    eval_once("R5", 8'hA2, 8'h9C, 8'h1C, 1'b0);
    eval_once("R5", 8'h25, 8'h80, 8'h00, 1'b1);
    eval_once("R5", 8'hA5, 8'h80, 8'h00, 1'b1);
    eval_once("R5", 8'h25, 8'h44, 8'h44, 1'b0);
    eval_once("R5", 8'hA5, 8'h44, 8'h44, 1'b0);
  endtask

  task automatic t_ignored_bits;
    eval_once("R9", 8'h7A, 8'h10, 8'h10, 1'b1);
    eval_once("R9", 8'h78, 8'h10, 8'h10, 1'b0);
    eval_once("R9", 8'hDC, 8'h80, 8'h01, 1'b0);
    eval_once("R9", 8'h5C, 8'h80, 8'h01, 1'b1);
  endtask

  task automatic t_idle_inputs;
    @(negedge clk);
    check_idle("R6");
    cmd_i = 8'h27; op_a_i = 8'hAA; op_b_i = 8'h55;
    @(negedge clk);
    check_idle("R10");
    cmd_i = 8'hA1; op_a_i = 8'hFF;
    @(negedge clk);
    check_idle("R10");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    eval_i = 1'b1; cmd_i = 8'h27; op_a_i = 8'h00; op_b_i = 8'h00;
    @(negedge clk);
    check("R6", "b2b done 1", int'(done_o), 1);
    check("R6", "b2b skip 1", int'(skip_o), 1);
    cmd_i = 8'h20;
    @(negedge clk);
    eval_i = 1'b0;
    check("R6", "b2b done 2", int'(done_o), 1);
    check("R6", "b2b skip 2", int'(skip_o), 0);
    check("R7", "b2b ticks 2", int'(ticks_o), 2);
    @(negedge clk);
    check_idle("R6");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    t_reset();
    t_constant();
    t_ordered(1'b0);
    t_ordered(1'b1);
    t_eq_ne();
    t_ignored_bits();
    t_idle_inputs();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule